// File: doc/BRIEF.md
# Selectable-Source Interrupt Router

This block raises interrupts on two request lines, A and B. Each line watches one of sixteen hardware event inputs. A 4-bit selector per line picks that input. The selected input is brought into the clock domain, and each rising edge on it sets a sticky status flag. Software reads and clears these flags through a small byte-wide register bus. It can also enable and disable each line through separate write-one bits.

A second enable path switches both lines together. It acts only on lines whose selector points into the timer group: the counter outputs, the external interrupt pin or general input bit 0. The byte that controls this path answers at two addresses.

The request outputs drive high while a line has both its flag and its enable set. Otherwise they float. They never pull low, so several boards can share one interrupt wire that has a single pull-down on it.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, selector A holds 0xA and selector B holds 0xC. Both status flags are 0, both enables are 0 and both request outputs float.
- R2: Address 0 is the selector register. Bits 3:0 hold selector A and bits 7:4 hold selector B. The register reads back what was written.
- R3: Selector code n picks event input bit n. Bits 0 to 9 are the counter outputs, bit 10 is the external interrupt pin, bit 11 is general input bit 0, and bits 12 to 15 are port bits.
- R4: A rising edge on the selected input passes a two-flop synchronizer. It sets the status flag on the third rising clock edge after the input rises, whether or not the line is enabled.
- R5: Address 1 reads status A in bit 0 and status B in bit 4. All other bits read 0. A status flag stays set until software writes 1 to its bit. Writing 0 leaves it unchanged, and a steady high input does not set it again.
- R6: At address 1, writing 1 to bit 2 (A) or bit 6 (B) enables the line, and writing 1 to bit 1 (A) or bit 5 (B) disables it. If both bits are 1 in one write, the disable wins.
- R7: A request output drives 1 exactly while its status flag and its enable are both 1. Otherwise it is high-impedance and never drives 0.
- R8: Address 2 and its shadow address 3 take a legacy byte. Bit 0 of that byte sets the enable of every line whose selector is 0x0 to 0xB, and clears it when 0. Lines with selectors 0xC to 0xF keep their enable. Both addresses read as 0x00.
- R9: If a write-1 clear arrives in the same cycle as a new synchronized edge, the flag stays set.
- R10: Edges on event inputs that no selector picks leave both status flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; read data is 0 when it is low |
| reg_rdata | output | 8 | Read data, combinational from the address |
| evt_in | input | 16 | Hardware event lines, asynchronous |
| irq_a | output | 1 | Request A, drives high or floats |
| irq_b | output | 1 | Request B, drives high or floats |

## Verification
The hardest case to reach is a clear write that lands in the same clock as a fresh synchronized edge. The bench first sets the flag and drops the input. It then raises the input again on a falling clock edge and times the clear write so that it is sampled on the third rising edge, which is the edge where the synchronized pulse arrives.

A changed selector is itself an edge when the newly picked line is high and the old one was low. The random phase holds the inputs steady across each selector write, so its model can predict that spurious set exactly.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;
    localparam int SRC_N   = 16;
    localparam int SEL_W   = $clog2(SRC_N);
    localparam int DATA_W  = 8;
    localparam int NUM_CH  = 2;

    localparam logic [SEL_W-1:0] RST_SEL_A  = 4'hA;
    localparam logic [SEL_W-1:0] RST_SEL_B  = 4'hC;
    localparam logic [SEL_W-1:0] TIMER_GRP_MAX = 4'hB;

    // per-channel command pulses decoded from one bus write
    typedef struct packed {
        logic clr;
        logic dis;
        logic ena;
        logic leg_wr;
        logic leg_en;
    } chan_cmd_t;
endpackage

// File: rtl/irq_src_sync.sv
`timescale 1ns/1ps
module irq_src_sync #(
    parameter int SRC_N  = 16,
    parameter int SEL_W  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] src_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             edge_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], src_i[sel_i]};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign edge_o = st_q.chain[STAGES-1] & ~st_q.prev;

    // one-cycle pulse: two consecutive edge pulses are impossible
    p_edge_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
endmodule

// File: rtl/irq_channel.sv
`timescale 1ns/1ps
module irq_channel
    import irq_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             edge_i,
    input  chan_cmd_t        cmd_i,
    output logic             sts_o,
    output logic             en_o
);
    typedef struct packed {
        logic sts;
        logic en;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     in_timer_grp;

    assign in_timer_grp = (sel_i <= TIMER_GRP_MAX);

    always_comb begin
        st_d = st_q;
        // a fresh edge beats a simultaneous clear
        if (edge_i)          st_d.sts = 1'b1;
        else if (cmd_i.clr)  st_d.sts = 1'b0;

        if (cmd_i.dis)                        st_d.en = 1'b0;
        else if (cmd_i.ena)                   st_d.en = 1'b1;
        else if (cmd_i.leg_wr && in_timer_grp) st_d.en = cmd_i.leg_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_o = st_q.sts;
    assign en_o  = st_q.en;

    p_edge_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i |=> sts_o);
    p_clear_only_by_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts_o) |-> $past(cmd_i.clr));
    p_disable_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.dis && cmd_i.ena) |=> !en_o);
    p_legacy_skips_ports_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.leg_wr && !cmd_i.ena && !cmd_i.dis && sel_i > TIMER_GRP_MAX) |=> $stable(en_o));
    p_edge_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && cmd_i.clr) |=> sts_o);
endmodule

// File: rtl/irq_reg_if.sv
`timescale 1ns/1ps
module irq_reg_if
    import irq_route_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [NUM_CH-1:0] sts_i,
    output logic [SEL_W-1:0]  sel_o [NUM_CH],
    output chan_cmd_t         cmd_o [NUM_CH],
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [ADDR_W-1:0] AD_SEL    = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] AD_CTL    = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] AD_LEG    = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] AD_LEG_SH = ADDR_W'(3);
    localparam int CH_BITS = DATA_W / NUM_CH;

    typedef struct packed {
        logic [SEL_W-1:0] sel_b;
        logic [SEL_W-1:0] sel_a;
    } sel_reg_t;

    sel_reg_t sel_d, sel_q;
    logic     wr_sel, wr_ctl, wr_leg;

    assign wr_sel = wr_i && (addr_i == AD_SEL);
    assign wr_ctl = wr_i && (addr_i == AD_CTL);
    assign wr_leg = wr_i && ((addr_i == AD_LEG) || (addr_i == AD_LEG_SH));

    always_comb begin
        sel_d = sel_q;
        if (wr_sel) sel_d = sel_reg_t'(wdata_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '{sel_b: RST_SEL_B, sel_a: RST_SEL_A};
        else        sel_q <= sel_d;
    end

    assign sel_o[0] = sel_q.sel_a;
    assign sel_o[1] = sel_q.sel_b;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmd
        always_comb begin
            cmd_o[ch].clr    = wr_ctl && wdata_i[ch*CH_BITS + 0];
            cmd_o[ch].dis    = wr_ctl && wdata_i[ch*CH_BITS + 1];
            cmd_o[ch].ena    = wr_ctl && wdata_i[ch*CH_BITS + 2];
            cmd_o[ch].leg_wr = wr_leg;
            cmd_o[ch].leg_en = wdata_i[0];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            unique case (addr_i)
                AD_SEL: rdata_o = sel_q;
                AD_CTL: begin
                    for (int ch = 0; ch < NUM_CH; ch++)
                        rdata_o[ch*CH_BITS] = sts_i[ch];
                end
                default: rdata_o = '0;
            endcase
        end
    end

    p_sel_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(sel_q));
endmodule

// File: rtl/irq_route_ctrl.sv
`timescale 1ns/1ps
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [7:0]        reg_rdata,
    input  logic [15:0]       evt_in,
    output wire               irq_a,
    output wire               irq_b
);
    logic [SEL_W-1:0]  sel   [NUM_CH];
    chan_cmd_t         cmd   [NUM_CH];
    logic [NUM_CH-1:0] edge_p;
    logic [NUM_CH-1:0] sts;
    logic [NUM_CH-1:0] en;
    logic [NUM_CH-1:0] drive;

    irq_reg_if #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .wr_i    (reg_wr),
        .rd_i    (reg_rd),
        .sts_i   (sts),
        .sel_o   (sel),
        .cmd_o   (cmd),
        .rdata_o (reg_rdata)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        irq_src_sync #(.SRC_N(SRC_N), .SEL_W(SEL_W), .STAGES(2)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (evt_in),
            .sel_i  (sel[ch]),
            .edge_o (edge_p[ch])
        );

        irq_channel u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel_i  (sel[ch]),
            .edge_i (edge_p[ch]),
            .cmd_i  (cmd[ch]),
            .sts_o  (sts[ch]),
            .en_o   (en[ch])
        );

        assign drive[ch] = sts[ch] & en[ch];
    end

    assign irq_a = drive[0] ? 1'b1 : 1'bz;
    assign irq_b = drive[1] ? 1'b1 : 1'bz;

    p_drive_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive[0]) |-> ($past(sts[0]) || $past(edge_p[0])));
endmodule

// File: tb/irq_route_ctrl_bench.sv
`timescale 1ns/1ps
module irq_route_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic [15:0] evt_in = '0;
    wire        irq_a_w;
    wire        irq_b_w;
    pulldown pd_a (irq_a_w);
    pulldown pd_b (irq_b_w);

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model
    logic [3:0] m_sel [2];
    logic [1:0] m_sts;
    logic [1:0] m_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_route_ctrl u_irq_route_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .evt_in(evt_in), .irq_a(irq_a_w), .irq_b(irq_b_w)
    );

    function automatic logic [7:0] exp_ctl(input logic [1:0] s);
        return {3'b000, s[1], 3'b000, s[0]};
    endfunction

    function automatic bit timer_grp(input logic [3:0] s);
        return s <= 4'hB;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // model updates
    task automatic m_write_sel(input logic [7:0] d);
        logic [3:0] nw [2];
        nw[0] = d[3:0]; nw[1] = d[7:4];
        bus_wr(3'd0, d);
        for (int c = 0; c < 2; c++) begin
            if (evt_in[nw[c]] && !evt_in[m_sel[c]]) m_sts[c] = 1'b1;
            m_sel[c] = nw[c];
        end
        idle(4);
    endtask

    task automatic m_write_ctl(input logic [7:0] d);
        bus_wr(3'd1, d);
        for (int c = 0; c < 2; c++) begin
            if (d[c*4]) m_sts[c] = 1'b0;
            if (d[c*4+1])      m_en[c] = 1'b0;
            else if (d[c*4+2]) m_en[c] = 1'b1;
        end
        idle(4);
    endtask

    task automatic m_write_leg(input logic [2:0] a, input logic [7:0] d);
        bus_wr(a, d);
        for (int c = 0; c < 2; c++)
            if (timer_grp(m_sel[c])) m_en[c] = d[0];
        idle(4);
    endtask

    task automatic m_set_evt(input logic [15:0] v);
        @(negedge clk);
        for (int c = 0; c < 2; c++)
            if (v[m_sel[c]] && !evt_in[m_sel[c]]) m_sts[c] = 1'b1;
        evt_in = v;
        idle(4);
    endtask

    task automatic check_all(input string req);
        logic [7:0] d;
        bus_rd(3'd1, d);
        check({req, " status"}, d, exp_ctl(m_sts));
        bus_rd(3'd0, d);
        check({req, " selectors"}, d, {m_sel[1], m_sel[0]});
        check({req, " irq_a"}, {7'd0, irq_a_w}, {7'd0, m_sts[0] & m_en[0]});
        check({req, " irq_b"}, {7'd0, irq_b_w}, {7'd0, m_sts[1] & m_en[1]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5EED_1234));
        m_sel[0] = 4'hA; m_sel[1] = 4'hC; m_sts = '0; m_en = '0;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state, R2 selector layout
        bus_rd(3'd0, d); check("R1 R2 reset selectors", d, 8'hCA);
        bus_rd(3'd1, d); check("R1 reset status", d, 8'h00);
        check("R1 R7 irq_a floats", {7'd0, irq_a_w}, 8'h00);
        check("R1 R7 irq_b floats", {7'd0, irq_b_w}, 8'h00);
        bus_rd(3'd2, d); check("R8 legacy reads zero", d, 8'h00);

        // R2 readback
        m_write_sel(8'h5B); check_all("R2");

        // R3 mapping and R10 ignored lines, channel A and B over every code
        for (int code = 0; code < 16; code++) begin
            m_set_evt(16'h0000);
            m_write_ctl(8'h11);
            m_write_sel({4'(15 - code), 4'(code)});
            m_write_ctl(8'h11);
            m_set_evt(~((16'h1 << code) | (16'h1 << (15 - code))));
            check_all("R10 other lines ignored");
            m_set_evt(16'hFFFF);
            check_all("R3 selected line sets flag");
        end

        // R5 sticky, write 0 no effect, steady high no re-set
        m_set_evt(16'h0000);
        m_write_sel(8'h21);
        m_set_evt(16'h0002);
        m_write_ctl(8'h00); check_all("R5 write zero keeps flag");
        m_write_ctl(8'h01); check_all("R5 clear with steady high");
        idle(6); check_all("R5 no re-set while high");

        // R4 latency: third rising edge
        m_set_evt(16'h0000);
        m_write_ctl(8'h11);
        @(negedge clk); evt_in = 16'h0002;
        @(negedge clk); @(negedge clk);
        reg_addr = 3'd1; reg_rd = 1'b1; #1 check("R4 not yet set after two edges", reg_rdata & 8'h01, 8'h00);
        reg_rd = 1'b0;
        @(negedge clk);
        reg_rd = 1'b1; #1 check("R4 set after third edge", reg_rdata & 8'h01, 8'h01);
        reg_rd = 1'b0;
        m_sts[0] = 1'b1;

        // R9 clear coinciding with edge
        m_set_evt(16'h0000);
        @(negedge clk); evt_in = 16'h0002;
        @(negedge clk); @(negedge clk);
        reg_addr = 3'd1; reg_wdata = 8'h01; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        idle(2);
        check_all("R9 edge beats clear");

        // R6 enable, disable, both
        m_write_ctl(8'h44); check_all("R6 R7 enable drives line");
        m_write_ctl(8'h06); check_all("R6 disable wins");
        m_write_ctl(8'h22); check_all("R6 disable B");

        // R8 legacy at shadow address, port-sourced channel untouched
        m_write_sel(8'hD3);
        m_set_evt(16'h2008);
        m_write_leg(3'd3, 8'h01); check_all("R8 shadow enables timer group only");
        m_write_ctl(8'h40);
        m_write_leg(3'd2, 8'h00); check_all("R8 legacy off keeps port channel");

        // random phase
        for (int it = 0; it < 400; it++) begin
            case ($urandom_range(0, 3))
                0: m_write_sel(8'($urandom));
                1: m_write_ctl(8'($urandom));
                2: m_write_leg(3'($urandom_range(2, 3)), 8'($urandom));
                default: m_set_evt(16'($urandom));
            endcase
            check_all("R4 R5 R6 R7 R8 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule